// File: doc/BRIEF.md
# Two-Channel Instruction Break Unit

This block watches an in-order instruction stream, one instruction slot per accepted transfer, and decides for each slot whether a debug break is due. Two channels, A and B, each hold one compare address and one condition type. A channel can check an instruction fetch before the instruction executes, check it after the instruction has completed, or check an operand access that the instruction makes. For every slot the unit reports whether the instruction must be suppressed, whether a break interrupt is requested, and which return address the handler has to save. Each channel also keeps a sticky match flag, which software clears by writing zero to it.

Slots arrive on a valid/ready input. The unit never applies back-pressure: `in_ready` is always high, and a slot is taken on every clock edge where `in_valid` is high. Each slot produces one result on the following cycle, marked by `res_valid`. The result carries no ready signal, and whoever consumes it must take it in that cycle. Cycles where `in_valid` is low leave all internal state unchanged. Instruction addresses step by 2 bytes.

Top module: `brk_unit`

## Requirements
- R1: After reset, `res_valid`, `res_supp`, `res_brk`, `res_ret` and both bits of `flags` are 0, and `in_ready` is 1.
- R2: A channel in mode 1 (pre-execution, channel A in `cfg_mode[1:0]`, channel B in `cfg_mode[3:2]`) whose address equals `in_pc` does three things. It sets its flag (bit 0 for A, bit 1 for B) in the cycle after the slot. It drives `res_supp`=1 and `res_brk`=1. It drives `res_ret`=`in_pc`. All of this holds even when `in_tlbmiss` or `in_retire` is 0.
- R3: In mode 2 (post-execution), a matching slot sets the flag only when `in_retire`=1. For a slot that is not a delayed branch, it then gives `res_brk`=1, `res_supp`=0 and `res_ret`=`in_pc`+2. A matching slot with `in_retire`=0 gives no flag and no break.
- R4: In mode 3 (operand access), a match needs both an address match and `in_opacc`=1. With `in_retire`=1 it sets the flag and breaks with `res_ret`=`in_pc`+2. With `in_retire`=0 (the slot was skipped by a taken branch, or the instruction before it took an exception) it does neither. The one exception is `in_multi`=1: the flag is then set with no break.
- R5: A completed mode 2 match on a slot with `in_dbr`=1 (delayed branch) gives no break on that slot. The break comes on the next accepted slot (the delay slot) instead. Its `res_ret` is `in_target` when `in_taken`=1, and the branch address plus 4 otherwise.
- R6: When channel A raises a pre-execution break on a slot, a pre-execution match on channel B in the next accepted slot sets no flag and raises no break. Later B matches behave normally.
- R7: When both channels match the same slot, both flags are set and one break result is produced.
- R8: Flags are sticky. With `clr_we`=1, a 0 in `clr_data` clears that flag and a 1 leaves it unchanged. A set in the same cycle wins over the clear.
- R9: `res_valid` is 1 exactly in the cycle after an accepted slot. Mode 0 disables a channel: it sets no flag and raises no break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_mode | input | 4 | Condition types: [1:0] channel A, [3:2] channel B; 0 off, 1 pre, 2 post, 3 operand |
| cfg_addr | input | 2*AW | Compare addresses: [AW-1:0] channel A, upper half channel B |
| clr_we | input | 1 | Flag write strobe |
| clr_data | input | 2 | Flag write data; a 0 clears that flag |
| in_valid | input | 1 | Instruction slot valid |
| in_ready | output | 1 | Always 1 |
| in_pc | input | AW | Fetch address of the slot |
| in_opacc | input | 1 | Slot makes an operand access |
| in_multi | input | 1 | Slot makes more than one operand access |
| in_retire | input | 1 | Slot completed execution |
| in_tlbmiss | input | 1 | Fetch suffered a translation miss |
| in_dbr | input | 1 | Slot is a delayed branch |
| in_taken | input | 1 | Delayed branch is taken |
| in_target | input | AW | Branch destination |
| res_valid | output | 1 | Result valid |
| res_supp | output | 1 | Suppress the slot's instruction |
| res_brk | output | 1 | Break interrupt request |
| res_ret | output | AW | Return address to save |
| flags | output | 2 | Sticky match flags, bit 0 A, bit 1 B |

## Verification
The hardest cases to reach are the ones that span two slots: the deferred break after a delayed branch, and the suppression of channel B right after a channel A pre-execution break. In both, the outcome depends on state carried between accepted slots. The bench sends a matching slot, then an idle cycle, then the follow-on slot, which shows that the carried state waits for the next accepted slot rather than the next clock. It then sends a fresh B match to show that the suppression lasts for one slot only.

// File: rtl/brk_pkg.sv
package brk_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_PRE  = 2'd1,
    MODE_POST = 2'd2,
    MODE_OPER = 2'd3
  } brk_mode_e;
  localparam int NCH = 2;
endpackage

// File: rtl/brk_chan.sv
module brk_chan
  import brk_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic [AW-1:0] addr,
  input  logic          valid,
  input  logic [AW-1:0] pc,
  input  logic          opacc,
  input  logic          multi,
  input  logic          retire,
  input  logic          dbr,
  input  logic          block,
  input  logic          supp,
  input  logic          clr_we,
  input  logic          clr_bit,
  output logic          pre_hit,
  output logic          brk_now,
  output logic          brk_defer,
  output logic          flag
);
  brk_mode_e m;
  logic eq, post_c, op_flag, op_brk, comp_hit, set;

  assign m        = brk_mode_e'(mode);
  assign eq       = (addr == pc);
  assign pre_hit  = valid && (m == MODE_PRE) && eq && !block;
  assign post_c   = valid && (m == MODE_POST) && eq && retire && !supp;
  assign op_flag  = valid && (m == MODE_OPER) && eq && opacc && !supp && (retire || multi);
  assign op_brk   = op_flag && retire;
  assign comp_hit = post_c || op_brk;
  assign brk_now  = comp_hit && !dbr;
  assign brk_defer = comp_hit && dbr;
  assign set      = pre_hit || post_c || op_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             flag <= 1'b0;
    else if (set)           flag <= 1'b1;
    else if (clr_we && !clr_bit) flag <= 1'b0;
  end
endmodule

// File: rtl/brk_ret.sv
module brk_ret #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid,
  input  logic [AW-1:0] pc,
  input  logic          taken,
  input  logic [AW-1:0] target,
  input  logic          any_pre,
  input  logic          any_now,
  input  logic          any_defer,
  output logic          res_valid,
  output logic          res_supp,
  output logic          res_brk,
  output logic [AW-1:0] res_ret
);
  localparam logic [AW-1:0] STEP = AW'(2);
  logic          pend;
  logic [AW-1:0] pend_addr;
  logic          brk;
  logic [AW-1:0] ret;

  assign brk = valid && (any_pre || any_now || pend);

  always_comb begin
    if (any_pre)   ret = pc;
    else if (pend) ret = pend_addr;
    else           ret = pc + STEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      pend_addr <= '0;
      res_valid <= 1'b0;
      res_supp  <= 1'b0;
      res_brk   <= 1'b0;
      res_ret   <= '0;
    end else begin
      res_valid <= valid;
      res_supp  <= valid && any_pre;
      res_brk   <= brk;
      res_ret   <= brk ? ret : '0;
      if (valid) begin
        pend      <= any_defer && !pend;
        pend_addr <= taken ? target : pc + STEP + STEP;
      end
    end
  end
endmodule

// File: rtl/brk_unit.sv
module brk_unit
  import brk_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2*NCH-1:0]    cfg_mode,
  input  logic [NCH*AW-1:0]   cfg_addr,
  input  logic                clr_we,
  input  logic [NCH-1:0]      clr_data,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [AW-1:0]       in_pc,
  input  logic                in_opacc,
  input  logic                in_multi,
  input  logic                in_retire,
  input  logic                in_tlbmiss,
  input  logic                in_dbr,
  input  logic                in_taken,
  input  logic [AW-1:0]       in_target,
  output logic                res_valid,
  output logic                res_supp,
  output logic                res_brk,
  output logic [AW-1:0]       res_ret,
  output logic [NCH-1:0]      flags
);
  logic [NCH-1:0] pre_hit, now_hit, defer_hit, blk;
  logic a_last, supp, tlb_unused;

  assign in_ready   = 1'b1;
  assign supp       = |pre_hit;
  assign tlb_unused = in_tlbmiss;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        a_last <= 1'b0;
    else if (in_valid) a_last <= pre_hit[0];
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    if (i == 1) begin : g_blk
      assign blk[i] = a_last;
    end else begin : g_free
      assign blk[i] = 1'b0;
    end
    brk_chan #(.AW(AW)) u_chan (
      .clk(clk), .rst_n(rst_n),
      .mode(cfg_mode[2*i +: 2]), .addr(cfg_addr[AW*i +: AW]),
      .valid(in_valid), .pc(in_pc), .opacc(in_opacc), .multi(in_multi),
      .retire(in_retire), .dbr(in_dbr), .block(blk[i]), .supp(supp),
      .clr_we(clr_we), .clr_bit(clr_data[i]),
      .pre_hit(pre_hit[i]), .brk_now(now_hit[i]), .brk_defer(defer_hit[i]),
      .flag(flags[i])
    );
  end

  brk_ret #(.AW(AW)) u_ret (
    .clk(clk), .rst_n(rst_n), .valid(in_valid), .pc(in_pc),
    .taken(in_taken), .target(in_target),
    .any_pre(supp), .any_now(|now_hit), .any_defer(|defer_hit),
    .res_valid(res_valid), .res_supp(res_supp), .res_brk(res_brk), .res_ret(res_ret)
  );
endmodule

// File: rtl/brk_unit_chk.sv
module brk_unit_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          clr_we,
  input logic [1:0]    clr_data,
  input logic          res_valid,
  input logic          res_supp,
  input logic          res_brk,
  input logic [1:0]    flags
);
  assert_valid_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid);
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> !res_brk && !res_supp);
  assert_supp_breaks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    res_supp |-> res_brk);
  assert_sticky_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flags[0] && !(clr_we && !clr_data[0]) |=> flags[0]);
  assert_sticky_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flags[1] && !(clr_we && !clr_data[1]) |=> flags[1]);
  assert_rise_on_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flags != 2'b00) && !$past(flags != 2'b00) |-> $past(in_valid));
endmodule

bind brk_unit brk_unit_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .clr_we(clr_we),
  .clr_data(clr_data), .res_valid(res_valid), .res_supp(res_supp),
  .res_brk(res_brk), .flags(flags)
);

// File: tb/brk_unit_bench.sv
module brk_unit_bench;
  localparam int AW = 32;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0, rst_n = 0;
  logic [3:0] cfg_mode = 0;
  logic [2*AW-1:0] cfg_addr = 0;
  logic clr_we = 0;
  logic [1:0] clr_data = 2'b11;
  logic in_valid = 0, in_opacc = 0, in_multi = 0, in_retire = 0;
  logic in_tlbmiss = 0, in_dbr = 0, in_taken = 0;
  logic [AW-1:0] in_pc = 0, in_target = 0;
  logic in_ready, res_valid, res_supp, res_brk;
  logic [AW-1:0] res_ret;
  logic [1:0] flags;
  int n_run = 0, n_fail = 0;

  brk_unit #(.AW(AW)) u_brk_unit (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic setup(logic [1:0] ma, logic [31:0] aa, logic [1:0] mb, logic [31:0] ab);
    cfg_mode = {mb, ma};
    cfg_addr = {ab, aa};
    @(negedge clk); clr_we = 1; clr_data = 2'b00;
    @(negedge clk); clr_we = 0; clr_data = 2'b11;
  endtask

  task automatic slot(logic [31:0] pc, logic ret, logic op = 0, logic mul = 0,
                      logic tlb = 0, logic dbr = 0, logic tk = 0, logic [31:0] tg = 0);
    in_valid = 1; in_pc = pc; in_retire = ret; in_opacc = op; in_multi = mul;
    in_tlbmiss = tlb; in_dbr = dbr; in_taken = tk; in_target = tg;
    @(negedge clk);
    in_valid = 0; in_retire = 0; in_opacc = 0; in_multi = 0; in_tlbmiss = 0; in_dbr = 0;
  endtask

  task automatic idle();
    @(negedge clk);
    chk("R9 idle res_valid", res_valid, 0);
  endtask

  task automatic t_reset();
    chk("R1 res_valid", res_valid, 0);
    chk("R1 res_brk", res_brk, 0);
    chk("R1 res_supp", res_supp, 0);
    chk("R1 res_ret", res_ret, 0);
    chk("R1 flags", flags, 0);
    chk("R1 in_ready", in_ready, 1);
  endtask

  task automatic t_pre();
    setup(2'd1, 32'h100, 2'd0, 32'h100);
    slot(32'h0FE, 1);
    chk("R2 no match brk", res_brk, 0);
    chk("R9 res_valid", res_valid, 1);
    chk("R9 mode0 B no flag", flags, 0);
    slot(32'h100, 0, 0, 0, 1);
    chk("R2 flag with tlb miss", flags, 2'b01);
    chk("R2 supp", res_supp, 1);
    chk("R2 brk", res_brk, 1);
    chk("R2 ret", res_ret, 32'h100);
  endtask

  task automatic t_post();
    setup(2'd2, 32'h200, 2'd0, 0);
    slot(32'h200, 0);
    chk("R3 unretired flag", flags, 0);
    chk("R3 unretired brk", res_brk, 0);
    slot(32'h200, 1);
    chk("R3 flag", flags, 2'b01);
    chk("R3 brk", res_brk, 1);
    chk("R3 no supp", res_supp, 0);
    chk("R3 ret", res_ret, 32'h202);
  endtask

  task automatic t_oper();
    setup(2'd3, 32'h300, 2'd0, 0);
    slot(32'h300, 1, 0);
    chk("R4 no opacc flag", flags, 0);
    slot(32'h300, 0, 1);
    chk("R4 skipped flag", flags, 0);
    chk("R4 skipped brk", res_brk, 0);
    slot(32'h300, 0, 1, 1);
    chk("R4 multi flag", flags, 2'b01);
    chk("R4 multi no brk", res_brk, 0);
    setup(2'd3, 32'h300, 2'd0, 0);
    slot(32'h300, 1, 1);
    chk("R4 retired flag", flags, 2'b01);
    chk("R4 retired brk", res_brk, 1);
    chk("R4 ret", res_ret, 32'h302);
  endtask

  task automatic t_dbr(logic tk, logic [31:0] exp);
    setup(2'd2, 32'h400, 2'd0, 0);
    slot(32'h400, 1, 0, 0, 0, 1, tk, 32'h800);
    chk("R5 flag on branch", flags, 2'b01);
    chk("R5 no brk on branch", res_brk, 0);
    idle();
    slot(32'h402, 1);
    chk("R5 brk on delay slot", res_brk, 1);
    chk("R5 ret", res_ret, exp);
    slot(32'h404, 1);
    chk("R5 single deferred brk", res_brk, 0);
  endtask

  task automatic t_block();
    setup(2'd1, 32'h500, 2'd1, 32'h502);
    slot(32'h500, 0);
    chk("R6 A brk", res_brk, 1);
    idle();
    slot(32'h502, 0);
    chk("R6 B flag blocked", flags, 2'b01);
    chk("R6 B brk blocked", res_brk, 0);
    slot(32'h600, 1);
    slot(32'h502, 0);
    chk("R6 B later flag", flags, 2'b11);
    chk("R6 B later brk", res_brk, 1);
  endtask

  task automatic t_both();
    setup(2'd2, 32'h700, 2'd3, 32'h700);
    slot(32'h700, 1, 1);
    chk("R7 both flags", flags, 2'b11);
    chk("R7 brk", res_brk, 1);
    chk("R7 ret", res_ret, 32'h702);
    slot(32'h704, 1);
    chk("R7 single brk", res_brk, 0);
  endtask

  task automatic t_clear();
    @(negedge clk); clr_we = 1; clr_data = 2'b10;
    @(negedge clk); clr_we = 0; clr_data = 2'b11;
    chk("R8 clear A keep B", flags, 2'b10);
    @(negedge clk); clr_we = 1; clr_data = 2'b11;
    @(negedge clk); clr_we = 0;
    chk("R8 write ones no effect", flags, 2'b10);
    cfg_mode = {2'd0, 2'd1}; cfg_addr = {32'h0, 32'h900};
    clr_we = 1; clr_data = 2'b00;
    slot(32'h900, 0);
    clr_we = 0; clr_data = 2'b11;
    chk("R8 set wins", flags, 2'b01);
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1; t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_pre();
    t_post();
    t_oper();
    t_dbr(1, 32'h800);
    t_dbr(0, 32'h404);
    t_block();
    t_both();
    t_clear();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule